// File: doc/BRIEF.md
# Dual-Width Accumulator ALU With Flags

This block is the arithmetic and logic stage of an accumulator-oriented processor core. Each accepted operation takes an operation code, the 16-bit accumulator, a 16-bit memory operand and the current n, v, z and c flags. One cycle later it presents a result, a write strobe that targets either the accumulator or memory, and the updated flag set. Operand fetch, addressing and decimal arithmetic are handled elsewhere.

A per-operation width select picks 8-bit or 16-bit operation. In 8-bit operation only the low byte takes part in the arithmetic and in flag generation. The high byte of the written value is carried through unchanged: from the accumulator when the accumulator is the target, and from the operand when memory is the target. Flag rules differ by operation. Some operations leave the carry or overflow untouched, compare and bit-test write nothing, and the byte swap always derives its flags from the new low byte.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `valid_o`, `acc_we_o` and `mem_we_o` are 0, and `res_o` and `flags_o` are 0.
- R2: An operation presented with `valid_i` high appears on the outputs after exactly one clock edge, with `valid_o` high. The flag vector is bit 3 n, bit 2 v, bit 1 z, bit 0 c on both `flags_i` and `flags_o`. With `valid_i` low, the next cycle shows `valid_o`, `acc_we_o` and `mem_we_o` at 0, and `res_o` and `flags_o` keep their previous values.
- R3: Add (code 0) produces acc + operand + c and writes the accumulator. c is the unsigned carry out of the active width, and v is set when both inputs share a sign bit and the sum's sign differs from it. n is the top bit of the result and z is set for a zero result.
- R4: Subtract (code 1) produces acc + NOT(operand) + c and writes the accumulator. c is set when no borrow occurs, v uses the inverted operand in the add rule, and n and z follow the result.
- R5: Compare (code 2) writes nothing and returns the accumulator unchanged on `res_o`. It sets c when acc >= operand (unsigned), sets z when they are equal and takes n from the top bit of acc - operand. v is kept.
- R6: Increment (code 3) and decrement (code 4) act on the accumulator by one and wrap within the active width. They update n and z and keep v and c.
- R7: AND (code 5), OR (code 6) and XOR (code 7) combine the accumulator and operand into the accumulator. They update n and z and keep v and c.
- R8: Bit test (code 8) writes nothing and returns the accumulator on `res_o`. n is the operand's top bit, v is operand bit 6 in 8-bit and bit 14 in 16-bit operation, z is set when acc AND operand is zero, and c is kept.
- R9: Test-and-set (code 9) writes operand OR acc to memory, and test-and-reset (code 10) writes operand AND NOT acc to memory. Both set z when acc AND operand is zero and keep n, v and c.
- R10: Shift left (code 11) and shift right (code 12) act on the accumulator and shift in 0. Left puts the old top bit into c, and right puts old bit 0 into c and always clears n. z follows the result, and n follows it for the left shift.
- R11: Rotate left (code 13) and rotate right (code 14) act on the accumulator, shift the old c in, and put the bit shifted out into c. The top bit is bit 7 or bit 15 by width. n and z follow the result.
- R12: Byte swap (code 15) exchanges the accumulator's two bytes in either width. n is the new bit 7 and z is set when the new low byte is zero, while v and c are kept.
- R13: With `byte_mode_i` high (8-bit), bits 15:8 of `res_o` equal the accumulator's high byte for accumulator-target operations other than the byte swap, and the operand's high byte for memory-target operations. Flags then depend only on bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| byte_mode_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| acc_i | input | 16 | Accumulator value |
| opnd_i | input | 16 | Memory operand |
| flags_i | input | 4 | Current flags {n,v,z,c} |
| valid_o | output | 1 | Registered result valid |
| res_o | output | 16 | Registered result |
| acc_we_o | output | 1 | Write result to accumulator |
| mem_we_o | output | 1 | Write result to memory |
| flags_o | output | 4 | Updated flags {n,v,z,c} |

## Verification
Width narrowing and carry/overflow generation act in the same cycle. An 8-bit add or subtract must take its carry from bit 7 while the untouched high byte is passed through. This is provoked with random high bytes that would produce a different carry in 16-bit operation, plus directed cases such as low byte 0xFF + 0x01 under a nonzero high byte. A reference model judges each case: it expects c from the low byte and the original high byte in bits 15:8. Rotates in byte mode with the carry set, and the byte swap under both widths, are judged the same way.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int W     = 16;
    localparam int H     = W / 2;
    localparam int LANES = W / H;

    typedef enum logic [3:0] {
        OP_ADC = 4'd0,  OP_SBC = 4'd1,  OP_CMP = 4'd2,  OP_INC = 4'd3,
        OP_DEC = 4'd4,  OP_AND = 4'd5,  OP_ORA = 4'd6,  OP_EOR = 4'd7,
        OP_BIT = 4'd8,  OP_TSB = 4'd9,  OP_TRB = 4'd10, OP_ASL = 4'd11,
        OP_LSR = 4'd12, OP_ROL = 4'd13, OP_ROR = 4'd14, OP_XBA = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {CL_ARITH, CL_LOGIC, CL_SHIFT} op_class_e;

    function automatic logic top_bit(logic [W-1:0] x, logic narrow);
        return narrow ? x[H-1] : x[W-1];
    endfunction

    function automatic logic sub_top_bit(logic [W-1:0] x, logic narrow);
        return narrow ? x[H-2] : x[W-2];
    endfunction

    function automatic logic is_zero(logic [W-1:0] x, logic narrow);
        return narrow ? (x[H-1:0] == '0) : (x == '0);
    endfunction

    function automatic op_class_e class_of(alu_op_e op);
        case (op)
            OP_ADC, OP_SBC, OP_CMP, OP_INC, OP_DEC: return CL_ARITH;
            OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_XBA: return CL_SHIFT;
            default:                                return CL_LOGIC;
        endcase
    endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import acc_alu_pkg::*;
(
    input  alu_op_e        op,
    input  logic           narrow,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           vout
);
    logic [W-1:0] bop;
    logic         ci;
    logic [W:0]   sum_w;
    logic [H:0]   sum_n;

    always_comb begin
        case (op)
            OP_SBC:  begin bop = ~b;  ci = cin;  end
            OP_CMP:  begin bop = ~b;  ci = 1'b1; end
            OP_INC:  begin bop = '0;  ci = 1'b1; end
            OP_DEC:  begin bop = '1;  ci = 1'b0; end
            default: begin bop = b;   ci = cin;  end
        endcase
        sum_w = {1'b0, a} + {1'b0, bop} + {{W{1'b0}}, ci};
        sum_n = {1'b0, a[H-1:0]} + {1'b0, bop[H-1:0]} + {{H{1'b0}}, ci};
        res   = narrow ? {a[W-1:H], sum_n[H-1:0]} : sum_w[W-1:0];
        cout  = narrow ? sum_n[H] : sum_w[W];
        vout  = (top_bit(a, narrow) == top_bit(bop, narrow)) &&
                (top_bit(res, narrow) != top_bit(a, narrow));
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import acc_alu_pkg::*;
(
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic [W-1:0]   common
);
    always_comb begin
        common = a & b;
        case (op)
            OP_ORA:  res = a | b;
            OP_EOR:  res = a ^ b;
            OP_TSB:  res = b | a;
            OP_TRB:  res = b & ~a;
            default: res = a & b;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import acc_alu_pkg::*;
(
    input  alu_op_e        op,
    input  logic           narrow,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    logic         fill_r;
    logic         fill_l;
    logic [W-1:0] right_w;
    logic [W-1:0] right_n;
    logic [W-1:0] left;

    always_comb begin
        fill_r  = (op == OP_ROR) ? cin : 1'b0;
        fill_l  = (op == OP_ROL) ? cin : 1'b0;
        right_w = {fill_r, a[W-1:1]};
        right_n = {a[W-1:H], fill_r, a[H-1:1]};
        left    = {a[W-2:0], fill_l};
        case (op)
            OP_ASL, OP_ROL: begin res = left; cout = top_bit(a, narrow); end
            OP_LSR, OP_ROR: begin res = narrow ? right_n : right_w; cout = a[0]; end
            default:        begin res = {a[H-1:0], a[W-1:H]}; cout = cin; end
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       valid_i,
    input  logic [3:0]                 op_i,
    input  logic                       byte_mode_i,
    input  logic [acc_alu_pkg::W-1:0]  acc_i,
    input  logic [acc_alu_pkg::W-1:0]  opnd_i,
    input  logic [3:0]                 flags_i,
    output logic                       valid_o,
    output logic [acc_alu_pkg::W-1:0]  res_o,
    output logic                       acc_we_o,
    output logic                       mem_we_o,
    output logic [3:0]                 flags_o
);
    alu_op_e      op;
    op_class_e    cls;
    flags_t       fin, fnx;
    logic [W-1:0] ar, lr, sr, common;
    logic         ac, av, sc;
    logic [W-1:0] raw, keep, merged, nz_src, res_nx;
    logic         to_mem, to_acc;

    assign op  = alu_op_e'(op_i);
    assign cls = class_of(op);
    assign fin = flags_t'(flags_i);

    alu_arith u_arith (
        .op(op), .narrow(byte_mode_i), .a(acc_i), .b(opnd_i), .cin(fin.c),
        .res(ar), .cout(ac), .vout(av)
    );

    alu_logic u_logic (
        .op(op), .a(acc_i), .b(opnd_i), .res(lr), .common(common)
    );

    alu_shift u_shift (
        .op(op), .narrow(byte_mode_i), .a(acc_i), .cin(fin.c),
        .res(sr), .cout(sc)
    );

    always_comb begin
        to_mem = (op == OP_TSB) || (op == OP_TRB);
        to_acc = !to_mem && (op != OP_CMP) && (op != OP_BIT);
        case (cls)
            CL_ARITH: nz_src = ar;
            CL_SHIFT: nz_src = sr;
            default:  nz_src = lr;
        endcase
        raw  = nz_src;
        keep = to_mem ? opnd_i : acc_i;
    end

    // byte lanes above the first keep their source in 8-bit operation
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_low
            assign merged[H-1:0] = raw[H-1:0];
        end else begin : g_high
            assign merged[l*H +: H] = (byte_mode_i && op != OP_XBA) ?
                                      keep[l*H +: H] : raw[l*H +: H];
        end
    end

    always_comb begin
        fnx    = fin;
        res_nx = to_acc || to_mem ? merged : acc_i;
        case (op)
            OP_ADC, OP_SBC: begin
                fnx.n = top_bit(nz_src, byte_mode_i);
                fnx.z = is_zero(nz_src, byte_mode_i);
                fnx.v = av;
                fnx.c = ac;
            end
            OP_CMP: begin
                fnx.n = top_bit(nz_src, byte_mode_i);
                fnx.z = is_zero(nz_src, byte_mode_i);
                fnx.c = ac;
            end
            OP_BIT: begin
                fnx.n = top_bit(opnd_i, byte_mode_i);
                fnx.v = sub_top_bit(opnd_i, byte_mode_i);
                fnx.z = is_zero(common, byte_mode_i);
            end
            OP_TSB, OP_TRB: begin
                fnx.z = is_zero(common, byte_mode_i);
            end
            OP_ASL, OP_ROL, OP_ROR: begin
                fnx.n = top_bit(nz_src, byte_mode_i);
                fnx.z = is_zero(nz_src, byte_mode_i);
                fnx.c = sc;
            end
            OP_LSR: begin
                fnx.n = 1'b0;
                fnx.z = is_zero(nz_src, byte_mode_i);
                fnx.c = sc;
            end
            OP_XBA: begin
                fnx.n = merged[H-1];
                fnx.z = (merged[H-1:0] == '0);
            end
            default: begin
                fnx.n = top_bit(nz_src, byte_mode_i);
                fnx.z = is_zero(nz_src, byte_mode_i);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            acc_we_o <= 1'b0;
            mem_we_o <= 1'b0;
            res_o    <= '0;
            flags_o  <= '0;
        end else begin
            valid_o  <= valid_i;
            acc_we_o <= valid_i && to_acc;
            mem_we_o <= valid_i && to_mem;
            if (valid_i) begin
                res_o   <= res_nx;
                flags_o <= fnx;
            end
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         valid_i,
    input logic [3:0]   op_i,
    input logic         byte_mode_i,
    input logic [W-1:0] acc_i,
    input logic [3:0]   flags_i,
    input logic         valid_o,
    input logic [W-1:0] res_o,
    input logic         acc_we_o,
    input logic         mem_we_o,
    input logic [3:0]   flags_o
);
    // R2: one target at most, and a cycle without an operation writes nothing
    a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
        !(acc_we_o && mem_we_o));
    a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!acc_we_o && !mem_we_o && !valid_o));
    // R5, R8: compare and bit test never write
    a_r5_r8_no_write: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == OP_CMP || op_i == OP_BIT)) |=> (!acc_we_o && !mem_we_o));
    // R6: inc/dec keep carry
    a_r6_keep_carry: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[0] == $past(flags_i[0])));
    // R10: right shift clears n
    a_r10_lsr_clears_n: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_LSR) |=> !flags_o[3]);
    // R12: byte swap result
    a_r12_swap: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_XBA) |=> (res_o == {$past(acc_i[H-1:0]), $past(acc_i[W-1:H])}));
    // R13: high byte preserved for 8-bit accumulator operations
    a_r13_high_kept: assert property (@(posedge clk) disable iff (rst)
        (valid_i && byte_mode_i && op_i != OP_XBA && op_i != OP_TSB && op_i != OP_TRB)
        |=> (res_o[W-1:H] == $past(acc_i[W-1:H])));
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .byte_mode_i(byte_mode_i), .acc_i(acc_i), .flags_i(flags_i),
    .valid_o(valid_o), .res_o(res_o), .acc_we_o(acc_we_o),
    .mem_we_o(mem_we_o), .flags_o(flags_o)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [3:0]  op_i;
    logic        byte_mode_i;
    logic [15:0] acc_i, opnd_i;
    logic [3:0]  flags_i;
    logic        valid_o, acc_we_o, mem_we_o;
    logic [15:0] res_o;
    logic [3:0]  flags_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .byte_mode_i(byte_mode_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .flags_i(flags_i), .valid_o(valid_o), .res_o(res_o),
        .acc_we_o(acc_we_o), .mem_we_o(mem_we_o), .flags_o(flags_o)
    );

    typedef struct {
        logic [15:0] res;
        logic        awe;
        logic        mwe;
        logic [3:0]  fl;
    } exp_t;

    task automatic check(string tag, string what, int unsigned act, int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int op);
        case (op)
            0:       return "R3";
            1:       return "R4";
            2:       return "R5";
            3, 4:    return "R6";
            5, 6, 7: return "R7";
            8:       return "R8";
            9, 10:   return "R9";
            11, 12:  return "R10";
            13, 14:  return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic exp_t model(int op, bit nb, logic [15:0] acc, logic [15:0] opnd, logic [3:0] fi);
        exp_t e;
        int unsigned wid  = nb ? 8 : 16;
        int unsigned mask = nb ? 32'hFF : 32'hFFFF;
        int unsigned a = acc & mask;
        int unsigned b = opnd & mask;
        int unsigned r = 0, s, bb;
        bit n = fi[3], v = fi[2], z = fi[1], c = fi[0];
        bit nz = 1, wr_acc = 1, wr_mem = 0;
        case (op)
            0: begin s = a + b + c; r = s & mask; c = (s >> wid) & 1;
                     v = (((a ^ r) & (b ^ r)) >> (wid - 1)) & 1; end
            1: begin bb = ~b & mask; s = a + bb + c; r = s & mask; c = (s >> wid) & 1;
                     v = (((a ^ r) & (bb ^ r)) >> (wid - 1)) & 1; end
            2: begin r = (a - b) & mask; c = (a >= b); wr_acc = 0; end
            3: r = (a + 1) & mask;
            4: r = (a - 1) & mask;
            5: r = a & b;
            6: r = a | b;
            7: r = a ^ b;
            8: begin nz = 0; wr_acc = 0; n = (b >> (wid - 1)) & 1;
                     v = (b >> (wid - 2)) & 1; z = ((a & b) == 0); end
            9: begin nz = 0; wr_acc = 0; wr_mem = 1; r = b | a; z = ((a & b) == 0); end
            10: begin nz = 0; wr_acc = 0; wr_mem = 1; r = b & ~a & mask; z = ((a & b) == 0); end
            11: begin c = (a >> (wid - 1)) & 1; r = (a << 1) & mask; end
            12: begin c = a & 1; r = a >> 1; end
            13: begin r = ((a << 1) | c) & mask; c = (a >> (wid - 1)) & 1; end
            14: begin r = (a >> 1) | (int'(c) << (wid - 1)); c = a & 1; end
            default: ;
        endcase
        if (nz) begin
            n = (r >> (wid - 1)) & 1;
            z = (r == 0);
        end
        if (op == 12) n = 0;
        if (op == 15) begin
            e.res = {acc[7:0], acc[15:8]};
            n = acc[15];
            z = (acc[15:8] == 0);
        end else if (!wr_acc && !wr_mem) e.res = acc;
        else if (nb) e.res = {wr_mem ? opnd[15:8] : acc[15:8], r[7:0]};
        else e.res = r[15:0];
        e.awe = wr_acc;
        e.mwe = wr_mem;
        e.fl  = {n, v, z, c};
        return e;
    endfunction

    task automatic run(int op, bit nb, logic [15:0] acc, logic [15:0] opnd, logic [3:0] fi);
        exp_t  e;
        string t;
        @(negedge clk);
        valid_i = 1'b1; op_i = op[3:0]; byte_mode_i = nb;
        acc_i = acc; opnd_i = opnd; flags_i = fi;
        e = model(op, nb, acc, opnd, fi);
        t = tag_of(op);
        @(negedge clk);
        check(t, "valid", valid_o, 1);
        check(t, "result", res_o, e.res);
        if (nb && op != 15) check("R13", "high byte", res_o[15:8], e.res[15:8]);
        check(t, "flags", flags_o, e.fl);
        check(t, "acc_we", acc_we_o, e.awe);
        check(t, "mem_we", mem_we_o, e.mwe);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        logic [15:0] hold_res;
        logic [3:0]  hold_fl;
        seed_init = $urandom(32'd20240611);
        rst = 1'b1; valid_i = 1'b0; op_i = '0; byte_mode_i = 1'b0;
        acc_i = '0; opnd_i = '0; flags_i = '0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", valid_o, 0);
        check("R1", "res in reset", res_o, 0);
        check("R1", "flags in reset", flags_o, 0);
        check("R1", "writes in reset", {acc_we_o, mem_we_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "writes after reset", {valid_o, acc_we_o, mem_we_o}, 0);

        // directed corners
        run(0, 1, 16'h127F, 16'hAA01, 4'b0000);   // R3 signed overflow in byte mode
        run(0, 1, 16'h34FF, 16'h0001, 4'b0000);   // R3 carry from bit 7, R13 high kept
        run(0, 0, 16'hFFFF, 16'h0000, 4'b0001);   // R3 16-bit wrap with carry in
        run(1, 0, 16'h0005, 16'h0005, 4'b0001);   // R4 equal, no borrow
        run(1, 1, 16'h0080, 16'h0001, 4'b0001);   // R4 signed overflow byte
        run(2, 0, 16'h0003, 16'h0005, 4'b0100);   // R5 less than, v kept
        run(2, 1, 16'hFF05, 16'h0005, 4'b0000);   // R5 equal in byte mode
        run(3, 0, 16'hFFFF, 16'h0000, 4'b0101);   // R6 wrap keeps v,c
        run(4, 1, 16'h5600, 16'h0000, 4'b0000);   // R6 byte wrap down
        run(8, 0, 16'h0000, 16'h4000, 4'b0001);   // R8 v from bit 14
        run(8, 1, 16'h0F0F, 16'h00C0, 4'b0000);   // R8 byte: n,v from bits 7,6
        run(9, 1, 16'h0F0F, 16'hAB30, 4'b1101);   // R9 set, operand high kept
        run(10, 0, 16'h00FF, 16'h12F0, 4'b0000);  // R9 reset bits
        run(12, 1, 16'h8001, 16'h0000, 4'b1000);  // R10 n cleared, c from bit 0
        run(11, 0, 16'h8000, 16'h0000, 4'b0000);  // R10 top bit to carry
        run(14, 1, 16'h3300, 16'h0000, 4'b0001);  // R11 carry into bit 7
        run(13, 0, 16'h8000, 16'h0000, 4'b0001);  // R11 16-bit rotate
        run(15, 1, 16'h8000, 16'h0000, 4'b0101);  // R12 swap in byte mode
        run(5, 0, 16'hF0F0, 16'h0F0F, 4'b0000);   // R7 zero result
        run(7, 1, 16'h11AA, 16'h2255, 4'b0000);   // R7 byte xor

        // R2: idle cycle holds outputs and writes nothing
        hold_res = res_o; hold_fl = flags_o;
        @(negedge clk);
        valid_i = 1'b0; op_i = 4'd0; acc_i = 16'h1234; opnd_i = 16'h1111;
        @(negedge clk);
        check("R2", "idle valid/writes", {valid_o, acc_we_o, mem_we_o}, 0);
        check("R2", "idle res held", res_o, hold_res);
        check("R2", "idle flags held", flags_o, hold_fl);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            run($urandom_range(0, 15), 1'($urandom_range(0, 1)),
                16'($urandom), 16'($urandom), 4'($urandom));
        end

        @(negedge clk);
        valid_i = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule